// File: doc/BRIEF.md
# Ring-Chained Segment DMA Channel

This block is one DMA channel that walks a small ring of link descriptors held in its own register file. Each descriptor names a source address, a destination address, a byte count and the index of the descriptor that follows it. After reset the next indices already form a closed ring (each entry points at the one after it, and the last points back to entry 0). One start command therefore keeps the channel cycling through the buffer until software aborts it. Every descriptor is one segment. Finishing a segment raises a status flag and, when enabled, the interrupt. Software uses this to refill the part of the buffer that has just been consumed.

Data moves one 32-bit word at a time. Each word is a read handshake on the memory port followed by a write handshake. The memory port uses valid/ready. Once the channel raises `mem_valid`, it holds `mem_addr`, `mem_we` and `mem_wdata` steady until the cycle in which `mem_ready` is high, so the memory side can stall for as long as it needs. The only way the channel withdraws a pending request is an abort or a start-while-busy halt. A read beat returns its data on `mem_rdata` in its accept cycle. A high `mem_err` in an accept cycle marks that beat as failed.

The peripheral side of a segment keeps one fixed address. In playback direction that is the destination; in capture direction it is the source. The memory side steps by 4 bytes per word. With pacing enabled, the channel waits for the peripheral's request line before each chunk of `CHUNK_BEATS` words.

Top module: `dma_ring_chan`

## Requirements
- R1: After reset, `mem_valid` and `irq` are low, the status register (offset 1) reads zero and the remaining-count register (offset 5) reads zero.
- R2: When a segment ends, the channel loads the descriptor named by that segment's next index without a new start. Status bit 3 (ring wrap) is set when that next index equals the first-descriptor index (offset 2, reset 0). With the reset ring of two entries, the transfer continues from descriptor 0 after descriptor 1.
- R3: The end of every segment sets status bit 0. While control bit 2 (segment interrupt enable) is 1 and status bit 0 is set, `irq` is high.
- R4: With control bit 5 at 0 (playback), every write of a segment goes to the descriptor's destination address, and reads step by 4 from its source. With control bit 5 at 1 (capture), every read comes from the fixed source, and writes step by 4 from its destination.
- R5: Writing 1 to a status bit at offset 1 clears it, writing 0 leaves it, and `irq` falls once the enabled causes are cleared. A new event in the same cycle as the clear wins.
- R6: Control bit 1 (abort) drops any memory request and makes the channel idle on the next edge. It clears the remaining count. While it reads 1, start (control bit 0, write-only) is ignored. Writing it back to 0 leaves the channel idle.
- R7: With control bit 4 (pacing) set, the channel issues no read while `periph_req` is low before a chunk. Each cycle in which `periph_req` is seen high lets exactly `CHUNK_BEATS` words through, or fewer if the segment ends first.
- R8: A start while the channel is busy, or while the remaining count is nonzero, sets status bit 2 (programming error) and leaves the channel idle with no request.
- R9: A descriptor whose byte count is zero or not a multiple of 4 sets status bit 2 when it is loaded and halts the channel before any memory access.
- R10: A beat accepted with `mem_err` high sets status bit 1 (transfer error) and halts the channel. Status bit 1 or bit 2 drives `irq` while control bit 3 (error interrupt enable) is set.
- R11: Offsets 3, 4 and 5 always return the current source address, the current destination address and the bytes left in the segment. Bytes left equals the count minus 4 per completed word.
- R12: Under back-pressure (`mem_valid` high and `mem_ready` low), the request's address, direction and write data stay stable. Each word still reaches its destination intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset (descriptor i field f at 16+4i+f: src, dst, count, next) |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data for `reg_addr` (combinational) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 write beat, 0 read beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid in the read accept cycle |
| mem_err | input | 1 | Beat accepted this cycle failed |
| periph_req | input | 1 | Peripheral request for the next paced chunk |
| irq | output | 1 | Interrupt |

## Verification
The ring is exercised in playback with a memory that accepts only every other cycle. This shows whether data is held under stall and whether the channel really reuses descriptor 0 with no second start. It is also exercised in capture against a fixed-address source that yields a counting stream, which separates the held side from the stepping side. A paced run with single-cycle request pulses separates chunk gating from free running, and the position registers are read while it is parked mid-segment. Error patterns use a memory that never answers, a failing memory, and zero and misaligned byte counts. These tell a busy-start, a bad descriptor and a bus fault apart by their status bits.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int OFF_CTRL   = 0;
  localparam int OFF_STAT   = 1;
  localparam int OFF_FIRST  = 2;
  localparam int OFF_CSRC   = 3;
  localparam int OFF_CDST   = 4;
  localparam int OFF_REMAIN = 5;
  localparam int OFF_DESC   = 16;

  localparam int CB_START = 0;
  localparam int CB_ABORT = 1;
  localparam int CB_SEGIE = 2;
  localparam int CB_ERRIE = 3;
  localparam int CB_PACE  = 4;
  localparam int CB_CAPT  = 5;

  localparam int SB_SEG  = 0;
  localparam int SB_XERR = 1;
  localparam int SB_PERR = 2;
  localparam int SB_WRAP = 3;
  localparam int SB_BUSY = 4;

  localparam int FLD_SRC = 0;
  localparam int FLD_DST = 1;
  localparam int FLD_CNT = 2;
  localparam int FLD_NXT = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_RD,
    ST_WR
  } xfer_state_t;
endpackage

// File: rtl/ring_desc_file.sv
module ring_desc_file #(
  parameter int NUM_DESC = 2,
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 32,
  parameter int IDX_W    = 1,
  parameter int REG_DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_fld,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [ADDR_W-1:0] eng_src,
  output logic [ADDR_W-1:0] eng_dst,
  output logic [CNT_W-1:0]  eng_cnt,
  output logic [IDX_W-1:0]  eng_nxt,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [1:0]        sw_fld,
  output logic [REG_DW-1:0] sw_data
);
  import dma_ring_pkg::*;

  logic [ADDR_W-1:0] src_q [NUM_DESC];
  logic [ADDR_W-1:0] dst_q [NUM_DESC];
  logic [CNT_W-1:0]  cnt_q [NUM_DESC];
  logic [IDX_W-1:0]  nxt_q [NUM_DESC];

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_entry
    localparam int RING_NEXT = (i + 1) % NUM_DESC;
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
        nxt_q[i] <= IDX_W'(RING_NEXT);
      end else if (hit) begin
        case (wr_fld)
          2'(FLD_SRC): src_q[i] <= wr_data[ADDR_W-1:0];
          2'(FLD_DST): dst_q[i] <= wr_data[ADDR_W-1:0];
          2'(FLD_CNT): cnt_q[i] <= wr_data[CNT_W-1:0];
          default:     nxt_q[i] <= wr_data[IDX_W-1:0];
        endcase
      end
    end
  end

  assign eng_src = src_q[eng_idx];
  assign eng_dst = dst_q[eng_idx];
  assign eng_cnt = cnt_q[eng_idx];
  assign eng_nxt = nxt_q[eng_idx];

  always_comb begin
    sw_data = '0;
    case (sw_fld)
      2'(FLD_SRC): sw_data = REG_DW'(src_q[sw_idx]);
      2'(FLD_DST): sw_data = REG_DW'(dst_q[sw_idx]);
      2'(FLD_CNT): sw_data = REG_DW'(cnt_q[sw_idx]);
      default:     sw_data = REG_DW'(nxt_q[sw_idx]);
    endcase
  end
endmodule

// File: rtl/ring_csr.sv
module ring_csr #(
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [5:1]       ctrl_wd,
  input  logic             stat_we,
  input  logic [3:0]       stat_wd,
  input  logic             first_we,
  input  logic [IDX_W-1:0] first_wd,
  input  logic             ev_seg,
  input  logic             ev_wrap,
  input  logic             ev_xerr,
  input  logic             ev_perr,
  output logic             abort_o,
  output logic             seg_ie_o,
  output logic             err_ie_o,
  output logic             pace_o,
  output logic             capture_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic [3:0]       status_o,
  output logic             irq_o
);
  import dma_ring_pkg::*;

  logic [5:1] ctrl_q;
  logic [3:0] stat_q;
  logic [3:0] set_v;
  logic [3:0] clr_v;

  assign set_v = {ev_wrap, ev_perr, ev_xerr, ev_seg};
  assign clr_v = stat_we ? stat_wd : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      stat_q      <= '0;
      first_idx_o <= '0;
    end else begin
      if (ctrl_we)  ctrl_q      <= ctrl_wd;
      if (first_we) first_idx_o <= first_wd;
      stat_q <= (stat_q & ~clr_v) | set_v;
    end
  end

  assign abort_o   = ctrl_q[CB_ABORT];
  assign seg_ie_o  = ctrl_q[CB_SEGIE];
  assign err_ie_o  = ctrl_q[CB_ERRIE];
  assign pace_o    = ctrl_q[CB_PACE];
  assign capture_o = ctrl_q[CB_CAPT];
  assign status_o  = stat_q;
  assign irq_o     = (seg_ie_o && stat_q[SB_SEG]) ||
                     (err_ie_o && (stat_q[SB_XERR] || stat_q[SB_PERR]));

  // R3: a finished segment with its interrupt enabled raises irq next cycle
  p_seg_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seg && seg_ie_o && !ctrl_we |=> irq_o);

  // R5: write-one clears a bit that no new event sets
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we && stat_wd[SB_SEG] && !ev_seg |=> !status_o[SB_SEG]);

  // R10: a bus fault is recorded
  p_xerr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xerr |=> status_o[SB_XERR]);
endmodule

// File: rtl/ring_xfer_engine.sv
module ring_xfer_engine #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int IDX_W       = 1,
  parameter int CHUNK_BEATS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              pace_i,
  input  logic              capture_i,
  input  logic [IDX_W-1:0]  first_idx_i,
  output logic [IDX_W-1:0]  desc_idx_o,
  input  logic [ADDR_W-1:0] desc_src_i,
  input  logic [ADDR_W-1:0] desc_dst_i,
  input  logic [CNT_W-1:0]  desc_cnt_i,
  input  logic [IDX_W-1:0]  desc_nxt_i,
  input  logic              periph_req_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_src_o,
  output logic [ADDR_W-1:0] cur_dst_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              ev_seg_o,
  output logic              ev_wrap_o,
  output logic              ev_xerr_o,
  output logic              ev_perr_o
);
  import dma_ring_pkg::*;

  localparam int BYTES = DATA_W / 8;
  localparam int BSH   = $clog2(BYTES);
  localparam int CHW   = $clog2(CHUNK_BEATS + 1);

  xfer_state_t       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  remain_q;
  logic [DATA_W-1:0] data_q;
  logic [CHW-1:0]    chunk_q;

  logic accept, beat_ok, bad_desc, bad_start, kill, seg_end, chunk_end;

  assign busy_o     = (state_q != ST_IDLE);
  assign accept     = mem_valid_o && mem_ready_i;
  assign beat_ok    = accept && !mem_err_i;
  assign bad_desc   = (desc_cnt_i == '0) || (desc_cnt_i[BSH-1:0] != '0);
  assign bad_start  = start_i && (busy_o || remain_q != '0);
  assign kill       = abort_i || bad_start;
  assign seg_end    = (state_q == ST_WR) && beat_ok && (remain_q == CNT_W'(BYTES)) && !kill;
  assign chunk_end  = pace_i && (chunk_q == CHW'(CHUNK_BEATS - 1));

  assign ev_seg_o  = seg_end;
  assign ev_wrap_o = seg_end && (desc_nxt_i == first_idx_i);
  assign ev_xerr_o = accept && mem_err_i && !kill;
  assign ev_perr_o = !abort_i && (bad_start || ((state_q == ST_LOAD) && bad_desc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      remain_q <= '0;
      data_q   <= '0;
      chunk_q  <= '0;
    end else if (abort_i) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
    end else if (bad_start) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q   <= first_idx_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (bad_desc) begin
          state_q <= ST_IDLE;
        end else begin
          src_q    <= desc_src_i;
          dst_q    <= desc_dst_i;
          remain_q <= desc_cnt_i;
          chunk_q  <= '0;
          state_q  <= pace_i ? ST_WAIT : ST_RD;
        end
        ST_WAIT: if (periph_req_i) state_q <= ST_RD;
        ST_RD: if (accept) begin
          if (mem_err_i) state_q <= ST_IDLE;
          else begin
            data_q  <= mem_rdata_i;
            state_q <= ST_WR;
          end
        end
        ST_WR: if (accept) begin
          if (mem_err_i) state_q <= ST_IDLE;
          else begin
            if (capture_i) dst_q <= dst_q + ADDR_W'(BYTES);
            else           src_q <= src_q + ADDR_W'(BYTES);
            remain_q <= remain_q - CNT_W'(BYTES);
            if (remain_q == CNT_W'(BYTES)) begin
              idx_q   <= desc_nxt_i;
              state_q <= ST_LOAD;
            end else if (chunk_end) begin
              chunk_q <= '0;
              state_q <= ST_WAIT;
            end else begin
              chunk_q <= chunk_q + 1'b1;
              state_q <= ST_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign desc_idx_o  = idx_q;
  assign mem_valid_o = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata_o = data_q;
  assign cur_src_o   = src_q;
  assign cur_dst_o   = dst_q;
  assign remain_o    = remain_q;

  // R6: abort stops traffic on the next edge
  p_abort_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !mem_valid_o && !busy_o);

  // R7: a paced chunk waits for the peripheral request
  p_pace_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) && !periph_req_i && !abort_i |=> !mem_valid_o);

  // R4: playback keeps the destination and steps the source
  p_hold_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR) && beat_ok && !kill && !capture_i
      |=> $stable(dst_q) && (src_q == $past(src_q) + ADDR_W'(BYTES)));

  // R4: capture keeps the source and steps the destination
  p_hold_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR) && beat_ok && !kill && capture_i
      |=> $stable(src_q) && (dst_q == $past(dst_q) + ADDR_W'(BYTES)));

  // R8: start while busy halts the channel
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o |=> !busy_o && !mem_valid_o);

  // R9: a bad descriptor never reaches the memory port
  p_bad_desc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) && bad_desc |=> !busy_o && !mem_valid_o);

  // R12: a stalled request holds its content
  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))
      || $past(abort_i) || $past(start_i));
endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan #(
  parameter int NUM_DESC    = 2,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int REG_DW      = 32,
  parameter int REG_AW      = 6,
  parameter int CHUNK_BEATS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  input  logic              periph_req,
  output logic              irq
);
  import dma_ring_pkg::*;

  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
  localparam int CNT_W = REG_DW;

  logic [REG_AW-1:0] desc_off;
  logic              desc_hit;
  logic [IDX_W-1:0]  sw_idx;
  logic [1:0]        sw_fld;
  logic              ctrl_we, stat_we, first_we, start;

  assign desc_off = reg_addr - REG_AW'(OFF_DESC);
  assign desc_hit = (reg_addr >= REG_AW'(OFF_DESC)) && (32'(desc_off) < 32'(4 * NUM_DESC));
  assign sw_idx   = desc_off[IDX_W+1:2];
  assign sw_fld   = desc_off[1:0];
  assign ctrl_we  = reg_wr && (reg_addr == REG_AW'(OFF_CTRL));
  assign stat_we  = reg_wr && (reg_addr == REG_AW'(OFF_STAT));
  assign first_we = reg_wr && (reg_addr == REG_AW'(OFF_FIRST));

  logic              abort, seg_ie, err_ie, pace, capture;
  logic [IDX_W-1:0]  first_idx, eng_idx, eng_nxt;
  logic [3:0]        status;
  logic [ADDR_W-1:0] eng_src, eng_dst, cur_src, cur_dst;
  logic [CNT_W-1:0]  eng_cnt, remain;
  logic [REG_DW-1:0] sw_data;
  logic              busy, ev_seg, ev_wrap, ev_xerr, ev_perr;

  assign start = ctrl_we && reg_wdata[CB_START] && !reg_wdata[CB_ABORT] && !abort;

  ring_desc_file #(
    .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .REG_DW(REG_DW)
  ) u_desc (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && desc_hit), .wr_idx(sw_idx), .wr_fld(sw_fld), .wr_data(reg_wdata),
    .eng_idx(eng_idx), .eng_src(eng_src), .eng_dst(eng_dst), .eng_cnt(eng_cnt), .eng_nxt(eng_nxt),
    .sw_idx(sw_idx), .sw_fld(sw_fld), .sw_data(sw_data)
  );

  ring_csr #(.IDX_W(IDX_W)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wd(reg_wdata[5:1]),
    .stat_we(stat_we), .stat_wd(reg_wdata[3:0]),
    .first_we(first_we), .first_wd(reg_wdata[IDX_W-1:0]),
    .ev_seg(ev_seg), .ev_wrap(ev_wrap), .ev_xerr(ev_xerr), .ev_perr(ev_perr),
    .abort_o(abort), .seg_ie_o(seg_ie), .err_ie_o(err_ie), .pace_o(pace), .capture_o(capture),
    .first_idx_o(first_idx), .status_o(status), .irq_o(irq)
  );

  ring_xfer_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .CHUNK_BEATS(CHUNK_BEATS)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .abort_i(abort), .pace_i(pace), .capture_i(capture), .first_idx_i(first_idx),
    .desc_idx_o(eng_idx), .desc_src_i(eng_src), .desc_dst_i(eng_dst), .desc_cnt_i(eng_cnt),
    .desc_nxt_i(eng_nxt), .periph_req_i(periph_req),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .busy_o(busy), .cur_src_o(cur_src), .cur_dst_o(cur_dst), .remain_o(remain),
    .ev_seg_o(ev_seg), .ev_wrap_o(ev_wrap), .ev_xerr_o(ev_xerr), .ev_perr_o(ev_perr)
  );

  always_comb begin
    reg_rdata = '0;
    if (desc_hit) reg_rdata = sw_data;
    else begin
      case (32'(reg_addr))
        OFF_CTRL: begin
          reg_rdata[CB_ABORT] = abort;
          reg_rdata[CB_SEGIE] = seg_ie;
          reg_rdata[CB_ERRIE] = err_ie;
          reg_rdata[CB_PACE]  = pace;
          reg_rdata[CB_CAPT]  = capture;
        end
        OFF_STAT: begin
          reg_rdata[3:0]     = status;
          reg_rdata[SB_BUSY] = busy;
        end
        OFF_FIRST:  reg_rdata = REG_DW'(first_idx);
        OFF_CSRC:   reg_rdata = REG_DW'(cur_src);
        OFF_CDST:   reg_rdata = REG_DW'(cur_dst);
        OFF_REMAIN: reg_rdata = REG_DW'(remain);
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/test_dma_ring_chan.sv
module test_dma_ring_chan;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FIFO_A = 32'h0000_0F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_valid, mem_we, irq;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_err = 1'b0;
  logic        periph_req = 1'b0;

  int errors = 0;
  int checks = 0;
  int rdy_mode = 0;
  int n_rd = 0;
  int n_wr = 0;
  logic [31:0] last_rd = '0;
  logic [31:0] fifo_val = 32'h5500;
  logic [31:0] mem_arr [0:1023];
  logic [31:0] wr_addr_log [0:63];
  logic [31:0] wr_data_log [0:63];
  logic        phase = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ring_chan i_dma_ring_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .periph_req(periph_req), .irq(irq)
  );

  assign mem_rdata = (mem_addr == FIFO_A) ? fifo_val : mem_arr[mem_addr[11:2]];

  always @(negedge clk) begin
    phase <= ~phase;
    mem_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? phase : 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready && !mem_err) begin
      if (mem_we) begin
        mem_arr[mem_addr[11:2]] <= mem_wdata;
        if (n_wr < 64) begin
          wr_addr_log[n_wr] <= mem_addr;
          wr_data_log[n_wr] <= mem_wdata;
        end
        n_wr <= n_wr + 1;
      end else begin
        last_rd <= mem_addr;
        n_rd <= n_rd + 1;
        if (mem_addr == FIFO_A) fifo_val <= fifo_val + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_desc(input int i, input logic [31:0] s, input logic [31:0] dd, input logic [31:0] c);
    wr(16 + 4*i + 0, s);
    wr(16 + 4*i + 1, dd);
    wr(16 + 4*i + 2, c);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
    check(irq === 1'b1, req, {31'b0, irq}, 32'h1);
  endtask

  task automatic idle_all();
    wr(0, 32'h2);
    wr(0, 32'h0);
    wr(1, 32'hF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(mem_valid === 1'b0, "R1 mem_valid", {31'b0, mem_valid}, 0);
    check(irq === 1'b0, "R1 irq", {31'b0, irq}, 0);
    rd(1, v); check(v == 0, "R1 status", v, 0);
    rd(5, v); check(v == 0, "R1 remain", v, 0);
  endtask

  task automatic t_playback_ring();
    logic [31:0] v;
    int base_w, base_r;
    bit ok;
    for (int k = 0; k < 6; k++) mem_arr[(32'h100 >> 2) + k] = 32'hA000 + k;
    rdy_mode = 1;
    set_desc(0, 32'h100, 32'h800, 16);
    set_desc(1, 32'h110, 32'h800, 8);
    base_w = n_wr; base_r = n_rd;
    wr(0, 32'h5);
    wait_irq("R3 irq after segment 0");
    rd(1, v);
    check(v[0] == 1'b1, "R3 seg bit", v, 32'h1);
    check(v[3] == 1'b0, "R2 no wrap after desc0", v, 32'h0);
    check(n_wr - base_w == 4, "R4 playback words seg0", n_wr - base_w, 4);
    ok = 1;
    for (int k = 0; k < 4; k++)
      if (wr_addr_log[base_w+k] != 32'h800 || wr_data_log[base_w+k] != 32'hA000 + k) ok = 0;
    check(ok, "R4 R12 fixed dst and ordered data", wr_data_log[base_w+3], 32'hA003);
    wr(1, 32'h1);
    rd(1, v);
    check(v[0] == 1'b0, "R5 seg bit cleared", v, 0);
    check(irq == 1'b0, "R5 irq dropped", {31'b0, irq}, 0);
    wait_irq("R3 irq after segment 1");
    rd(1, v);
    check(v[3] == 1'b1, "R2 wrap bit", v, 32'h8);
    check(n_wr - base_w == 6, "R2 second descriptor words", n_wr - base_w, 6);
    check(wr_data_log[base_w+5] == 32'hA005, "R12 last word", wr_data_log[base_w+5], 32'hA005);
    wr(1, 32'hF);
    begin
      int n = 0;
      while (n_rd - base_r < 7 && n < 200) begin @(negedge clk); n++; end
    end
    check(last_rd == 32'h100, "R2 ring restart at desc0", last_rd, 32'h100);
    wr(0, 32'h2);
    @(negedge clk);
    check(mem_valid == 1'b0, "R6 abort drops request", {31'b0, mem_valid}, 0);
    rd(1, v); check(v[4] == 1'b0, "R6 idle after abort", v, 0);
    rd(5, v); check(v == 0, "R6 remain cleared", v, 0);
    base_r = n_rd;
    wr(0, 32'h3);
    repeat (6) @(negedge clk);
    check(n_rd == base_r, "R6 start ignored under abort", n_rd, base_r);
    wr(0, 32'h0);
    repeat (3) @(negedge clk);
    rd(1, v); check(v[4] == 1'b0 && n_rd == base_r, "R6 idle after abort release", v, 0);
    wr(1, 32'hF);
    rdy_mode = 0;
  endtask

  task automatic t_capture();
    logic [31:0] v;
    fifo_val = 32'h5500;
    set_desc(0, FIFO_A, 32'h200, 12);
    set_desc(1, FIFO_A, 32'h240, 4);
    wr(0, 32'h25);
    wait_irq("R3 capture irq");
    check(mem_arr[32'h200 >> 2] == 32'h5500 && mem_arr[(32'h204) >> 2] == 32'h5501
          && mem_arr[32'h208 >> 2] == 32'h5502, "R4 capture stepping destination",
          mem_arr[32'h208 >> 2], 32'h5502);
    rd(3, v); check(v == FIFO_A, "R4 capture source held", v, FIFO_A);
    idle_all();
  endtask

  task automatic t_pacing();
    logic [31:0] v;
    int base_r, base_w;
    periph_req = 1'b0;
    set_desc(0, 32'h300, 32'hA00, 16);
    set_desc(1, 32'h300, 32'hA00, 8);
    base_r = n_rd; base_w = n_wr;
    wr(0, 32'h15);
    repeat (10) @(negedge clk);
    check(n_rd == base_r, "R7 no read before request", n_rd, base_r);
    periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
    repeat (10) @(negedge clk);
    check(n_wr - base_w == 2, "R7 one chunk per request", n_wr - base_w, 2);
    rd(5, v); check(v == 8, "R11 remaining bytes", v, 8);
    rd(3, v); check(v == 32'h308, "R11 current source", v, 32'h308);
    rd(4, v); check(v == 32'hA00, "R11 current destination", v, 32'hA00);
    periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
    repeat (10) @(negedge clk);
    rd(1, v); check(v[0] == 1'b1 && n_wr - base_w == 4, "R7 R3 segment done after two chunks", v, 32'h1);
    idle_all();
  endtask

  task automatic t_busy_start();
    logic [31:0] v;
    rdy_mode = 2;
    set_desc(0, 32'h100, 32'h800, 8);
    wr(0, 32'h1);
    repeat (3) @(negedge clk);
    rd(1, v); check(v[4] == 1'b1, "R8 busy before second start", v, 32'h10);
    wr(0, 32'h1);
    rd(1, v); check(v[2] == 1'b1 && v[4] == 1'b0, "R8 start while busy", v, 32'h4);
    check(mem_valid == 1'b0, "R8 request withdrawn", {31'b0, mem_valid}, 0);
    idle_all();
    rdy_mode = 0;
  endtask

  task automatic t_bad_desc();
    logic [31:0] v;
    int base_r;
    base_r = n_rd;
    set_desc(0, 32'h100, 32'h800, 0);
    wr(0, 32'h9);
    repeat (4) @(negedge clk);
    rd(1, v); check(v[2] == 1'b1 && n_rd == base_r, "R9 zero count", v, 32'h4);
    check(irq == 1'b1, "R10 error irq on programming error", {31'b0, irq}, 1);
    idle_all();
    wr(16 + 2, 6);
    wr(0, 32'h9);
    repeat (4) @(negedge clk);
    rd(1, v); check(v[2] == 1'b1 && v[4] == 1'b0 && n_rd == base_r, "R9 misaligned count", v, 32'h4);
    idle_all();
  endtask

  task automatic t_xfer_err();
    logic [31:0] v;
    set_desc(0, 32'h100, 32'h800, 8);
    mem_err = 1'b1;
    wr(0, 32'h9);
    repeat (4) @(negedge clk);
    rd(1, v); check(v[1] == 1'b1 && v[4] == 1'b0, "R10 transfer error halts", v, 32'h2);
    check(irq == 1'b1, "R10 error irq", {31'b0, irq}, 1);
    mem_err = 1'b0;
    wr(1, 32'hF);
    wr(0, 32'h9);
    rd(1, v); check(v[2] == 1'b1 && v[4] == 1'b0, "R8 start with nonzero remain", v, 32'h4);
    idle_all();
    rd(5, v); check(v == 0, "R6 abort clears remain", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 1024; k++) mem_arr[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_playback_ring();
    t_capture();
    t_pacing();
    t_busy_start();
    t_bad_desc();
    t_xfer_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule